// File: doc/BRIEF.md
# GPIO Pad Drive Resolver

This block decides, for every pin of a general purpose I/O port, what the pad is actually doing. It combines three things: the output latch bit, the per-pin configuration word and an external stimulus. The configuration word holds direction, input buffer disconnect, pull selection and drive mode. The external stimulus is a drive-valid bit plus a level. From these the block derives the driven state of the pad, the value the input register should capture, whether two drivers fight, and a single-cycle strobe that marks a change in the driven state.

The resolution is purely per pin and is replicated across a parameterised number of pins. All outputs are registered, so every result appears one clock after the inputs that produce it. Configuration storage and bus access live elsewhere. Strong and high drive strengths are not told apart.

Top module: `gpio_drive_resolve`

## Requirements
- R1: While `rst` is high at a clock edge, every output bit is 0 after that edge.
- R2: The configuration word of each pin is 11 bits wide. Bit 0 is the direction (1 = output), bit 1 is the input buffer disconnect (1 = disconnected), bits 3:2 are the pull selection and bits 10:8 are the drive mode. The internal driver is on only when the direction is output and the drive mode connects for the current latch bit. Modes 0 to 3 always connect. Modes 4 and 5 do not connect when the latch bit is 0. Modes 6 and 7 do not connect when the latch bit is 1. With the driver on, `pad_oe_o` is 1 and `pad_lvl_o` equals the latch bit.
- R3: Pull selection 1 is pull-down (level 0) and 3 is pull-up (level 1). Values 0 and 2 mean no pull. When the internal driver is off, a pull is selected and `ext_vld_i` is 0, the pad counts as driven: `pad_oe_o` is 1 and `pad_lvl_o` is the pull level. A valid external drive suppresses this.
- R4: `pad_lvl_o` is 0 for every pin whose `pad_oe_o` is 0.
- R5: With the input buffer connected and `ext_vld_i` set, `in_o` equals `ext_lvl_i`.
- R6: With the input buffer connected and `ext_vld_i` clear, `in_o` equals the pad level when the pad is driven, and equals `ext_lvl_i` otherwise.
- R7: With the input buffer disconnected, `in_o` is 1 for pull-up and 0 for any other pull selection, whatever the external stimulus.
- R8: `short_o` is 1 exactly when the internal driver is on, `ext_vld_i` is set and `ext_lvl_i` differs from the latch bit.
- R9: `chg_o` is 1 in the cycle where a pin's `pad_oe_o` or `pad_lvl_o` differs from its value in the previous cycle. Leaving reset with an undriven pin gives no strobe.
- R10: Each output reflects the inputs that were present at the preceding rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| out_latch_i | input | NUM_PINS | Output latch bit for each pin |
| cfg_i | input | NUM_PINS*11 | Configuration words, pin 0 in the lowest 11 bits |
| ext_vld_i | input | NUM_PINS | External side drives the pin |
| ext_lvl_i | input | NUM_PINS | Level from the external side |
| in_o | output | NUM_PINS | Value for the input register |
| pad_oe_o | output | NUM_PINS | Pad is driven, internally or by pull |
| pad_lvl_o | output | NUM_PINS | Driven pad level |
| short_o | output | NUM_PINS | Internal and external drives conflict |
| chg_o | output | NUM_PINS | Driven state changed this cycle |

## Verification
Every drive mode is tried with both latch levels, with the direction bit set and with it clear. This separates the two one-sided disconnect ranges from the always-connected range. Pull selections are tried with and without an external drive, which shows whether a pull only stands in for a missing driver. External drives that agree with the output and external drives that oppose it separate a real short from plain coexistence. Disconnected-buffer patterns with an active external drive show that the buffer ignores that drive. Holding a pattern for a second cycle, and leaving reset undriven, show that the strobe marks a change rather than a state.

// File: rtl/gpio_res_pkg.sv
package gpio_res_pkg;
  localparam int CFG_W = 11;

  typedef struct packed {
    logic [2:0] drv;
    logic [3:0] rsvd;
    logic [1:0] pull;
    logic       disc;
    logic       dir;
  } pin_cfg_t;

  localparam logic [1:0] PULL_DN = 2'd1;
  localparam logic [1:0] PULL_UP = 2'd3;

  // Drive mode decides whether the driver is attached for a given level
  function automatic logic drv_connects(input logic [2:0] code, input logic lvl);
    case (code[2:1])
      2'b10:   return lvl;
      2'b11:   return !lvl;
      default: return 1'b1;
    endcase
  endfunction
endpackage

// File: rtl/gpio_pin_resolve.sv
module gpio_pin_resolve
  import gpio_res_pkg::*;
(
  input  pin_cfg_t cfg,
  input  logic     out_bit,
  input  logic     ext_vld,
  input  logic     ext_lvl,
  output logic     oe,
  output logic     lvl,
  output logic     in_bit,
  output logic     short_bit
);
  logic int_on;
  logic pull_en;
  logic pull_lvl;
  logic pull_act;

  always_comb begin
    int_on    = cfg.dir & drv_connects(cfg.drv, out_bit);
    pull_en   = (cfg.pull == PULL_DN) || (cfg.pull == PULL_UP);
    pull_lvl  = (cfg.pull == PULL_UP);
    pull_act  = pull_en & ~ext_vld & ~int_on;
    oe        = int_on | pull_act;
    lvl       = int_on ? out_bit : (pull_act & pull_lvl);
    if (cfg.disc)
      in_bit = pull_lvl;
    else if (!ext_vld && oe)
      in_bit = lvl;
    else
      in_bit = ext_lvl;
    short_bit = int_on & ext_vld & (out_bit != ext_lvl);
  end
endmodule

// File: rtl/gpio_pad_regs.sv
module gpio_pad_regs #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] d_oe,
  input  logic [NUM_PINS-1:0] d_lvl,
  input  logic [NUM_PINS-1:0] d_in,
  input  logic [NUM_PINS-1:0] d_short,
  output logic [NUM_PINS-1:0] q_oe,
  output logic [NUM_PINS-1:0] q_lvl,
  output logic [NUM_PINS-1:0] q_in,
  output logic [NUM_PINS-1:0] q_short,
  output logic [NUM_PINS-1:0] q_chg
);
  // The registered pad state doubles as the record of the previous state
  always_ff @(posedge clk) begin
    if (rst) begin
      q_oe    <= '0;
      q_lvl   <= '0;
      q_in    <= '0;
      q_short <= '0;
      q_chg   <= '0;
    end else begin
      q_oe    <= d_oe;
      q_lvl   <= d_lvl;
      q_in    <= d_in;
      q_short <= d_short;
      q_chg   <= (d_oe ^ q_oe) | (d_lvl ^ q_lvl);
    end
  end
endmodule

// File: rtl/gpio_drive_resolve.sv
module gpio_drive_resolve
  import gpio_res_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PINS-1:0]       out_latch_i,
  input  logic [NUM_PINS*CFG_W-1:0] cfg_i,
  input  logic [NUM_PINS-1:0]       ext_vld_i,
  input  logic [NUM_PINS-1:0]       ext_lvl_i,
  output logic [NUM_PINS-1:0]       in_o,
  output logic [NUM_PINS-1:0]       pad_oe_o,
  output logic [NUM_PINS-1:0]       pad_lvl_o,
  output logic [NUM_PINS-1:0]       short_o,
  output logic [NUM_PINS-1:0]       chg_o
);
  logic [NUM_PINS-1:0] oe_c, lvl_c, in_c, short_c;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    gpio_pin_resolve u_pin (
      .cfg      (pin_cfg_t'(cfg_i[p*CFG_W +: CFG_W])),
      .out_bit  (out_latch_i[p]),
      .ext_vld  (ext_vld_i[p]),
      .ext_lvl  (ext_lvl_i[p]),
      .oe       (oe_c[p]),
      .lvl      (lvl_c[p]),
      .in_bit   (in_c[p]),
      .short_bit(short_c[p])
    );
  end

  gpio_pad_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .d_oe   (oe_c),
    .d_lvl  (lvl_c),
    .d_in   (in_c),
    .d_short(short_c),
    .q_oe   (pad_oe_o),
    .q_lvl  (pad_lvl_o),
    .q_in   (in_o),
    .q_short(short_o),
    .q_chg  (chg_o)
  );
endmodule

// File: rtl/gpio_drive_resolve_chk.sv
module gpio_drive_resolve_chk #(
  parameter int NUM_PINS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_PINS-1:0] in_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_lvl_o,
  input logic [NUM_PINS-1:0] short_o,
  input logic [NUM_PINS-1:0] chg_o
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (in_o == '0 && pad_oe_o == '0 && pad_lvl_o == '0 && short_o == '0 && chg_o == '0));

  assert_lvl_needs_oe_R4: assert property (@(posedge clk) disable iff (rst)
    (pad_lvl_o & ~pad_oe_o) == '0);

  assert_short_driven_R8: assert property (@(posedge clk) disable iff (rst)
    (short_o & ~pad_oe_o) == '0);

  assert_strobe_on_change_R9: assert property (@(posedge clk) disable iff (rst)
    chg_o == ((pad_oe_o ^ $past(pad_oe_o)) | (pad_lvl_o ^ $past(pad_lvl_o))));
endmodule

bind gpio_drive_resolve gpio_drive_resolve_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_o     (in_o),
  .pad_oe_o (pad_oe_o),
  .pad_lvl_o(pad_lvl_o),
  .short_o  (short_o),
  .chg_o    (chg_o)
);

// File: tb/tb_gpio_drive_resolve.sv
module tb_gpio_drive_resolve;
  localparam int N  = 32;
  localparam int CW = 11;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    out_latch = '0;
  logic [N*CW-1:0] cfg = '0;
  logic [N-1:0]    ext_vld = '0;
  logic [N-1:0]    ext_lvl = '0;
  logic [N-1:0]    in_o, pad_oe_o, pad_lvl_o, short_o, chg_o;

  int checks = 0;
  int fails  = 0;
  logic [N-1:0] prev_oe = '0;
  logic [N-1:0] prev_lvl = '0;

  always #5 clk = ~clk;

  gpio_drive_resolve #(.NUM_PINS(N)) dut (
    .clk(clk), .rst(rst), .out_latch_i(out_latch), .cfg_i(cfg),
    .ext_vld_i(ext_vld), .ext_lvl_i(ext_lvl), .in_o(in_o),
    .pad_oe_o(pad_oe_o), .pad_lvl_o(pad_lvl_o), .short_o(short_o), .chg_o(chg_o)
  );

  function automatic logic [CW-1:0] mk_cfg(logic dir, logic disc, logic [1:0] pull, logic [2:0] drv);
    return {drv, 4'b0, pull, disc, dir};
  endfunction

  task automatic chk(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected values derived from the requirement text
  task automatic model(output logic [N-1:0] e_oe, e_lvl, e_in, e_sh);
    for (int p = 0; p < N; p++) begin
      logic [CW-1:0] c;
      logic conn, drv_on, pull_on, pull_hi, ob;
      c = cfg[p*CW +: CW];
      ob = out_latch[p];
      case (c[10:8])
        3'd4, 3'd5: conn = ob;
        3'd6, 3'd7: conn = !ob;
        default:    conn = 1'b1;
      endcase
      drv_on  = c[0] && conn;
      pull_on = (c[3:2] == 2'd1 || c[3:2] == 2'd3) && !ext_vld[p] && !drv_on;
      pull_hi = (c[3:2] == 2'd3);
      e_oe[p]  = drv_on || pull_on;
      e_lvl[p] = drv_on ? ob : (pull_on && pull_hi);
      if (c[1])                       e_in[p] = pull_hi;
      else if (!ext_vld[p] && e_oe[p]) e_in[p] = e_lvl[p];
      else                             e_in[p] = ext_lvl[p];
      e_sh[p] = drv_on && ext_vld[p] && (ob != ext_lvl[p]);
    end
  endtask

  // Inputs are set at a falling edge; result is visible after the next rising edge (R10)
  task automatic step_check(string req);
    logic [N-1:0] e_oe, e_lvl, e_in, e_sh;
    model(e_oe, e_lvl, e_in, e_sh);
    @(posedge clk);
    @(negedge clk);
    chk(req, "pad_oe", pad_oe_o, e_oe);
    chk(req, "pad_lvl", pad_lvl_o, e_lvl);
    chk(req, "in", in_o, e_in);
    chk(req, "short", short_o, e_sh);
    chk("R9", "chg", chg_o, (e_oe ^ prev_oe) | (e_lvl ^ prev_lvl));
    prev_oe  = e_oe;
    prev_lvl = e_lvl;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "pad_oe", pad_oe_o, '0);
    chk("R1", "in", in_o, '0);
    chk("R1", "chg", chg_o, '0);
    rst = 1'b0;
    step_check("R9");
    chk("R9", "no strobe leaving reset undriven", chg_o, '0);
  endtask

  task automatic t_drive_codes();
    for (int lv = 0; lv < 2; lv++) begin
      for (int p = 0; p < N; p++) begin
        cfg[p*CW +: CW] = mk_cfg(p < 16, 1'b0, 2'd0, 3'(p % 8));
        out_latch[p] = 1'(lv);
      end
      ext_vld = '0;
      step_check("R2");
      chk("R2", "code4 pin4", {31'b0, pad_oe_o[4]}, {31'b0, 1'(lv)});
      chk("R2", "code6 pin6", {31'b0, pad_oe_o[6]}, {31'b0, 1'(lv == 0)});
      chk("R2", "dir0 pin16", {31'b0, pad_oe_o[16]}, '0);
      chk("R4", "lvl when undriven", pad_lvl_o & ~pad_oe_o, '0);
    end
    step_check("R9");
    chk("R9", "steady pattern strobe", chg_o, '0);
  endtask

  task automatic t_pulls();
    for (int p = 0; p < N; p++) begin
      cfg[p*CW +: CW] = mk_cfg(1'b0, 1'b0, 2'(p % 4), 3'd0);
      out_latch[p] = 1'b1;
    end
    ext_vld = '0;
    ext_lvl = '0;
    step_check("R3");
    chk("R3", "pull-up pin3 level", {31'b0, pad_lvl_o[3]}, 32'd1);
    chk("R6", "in follows pull-up pin3", {31'b0, in_o[3]}, 32'd1);
    ext_vld = 32'h0000_FFFF;
    ext_lvl = 32'h0000_F0F0;
    step_check("R3");
    chk("R5", "in follows external", in_o & ext_vld, ext_lvl & ext_vld);
  endtask

  task automatic t_shorts();
    for (int p = 0; p < N; p++)
      cfg[p*CW +: CW] = mk_cfg(1'b1, 1'b0, 2'd0, 3'(p % 8));
    out_latch = 32'hAAAA_5555;
    ext_vld   = 32'hFF00_FF00;
    ext_lvl   = 32'h0F0F_0F0F;
    step_check("R8");
    ext_lvl = out_latch;
    step_check("R8");
    chk("R8", "agreeing drives", short_o, '0);
  endtask

  task automatic t_disconnect();
    for (int p = 0; p < N; p++)
      cfg[p*CW +: CW] = mk_cfg(1'(p % 2), 1'b1, 2'(p % 4), 3'd0);
    out_latch = 32'hFFFF_0000;
    ext_vld   = 32'hFFFF_FFFF;
    ext_lvl   = 32'hFFFF_FFFF;
    step_check("R7");
    chk("R7", "in only for pull-up", in_o, 32'h8888_8888);
    ext_vld = '0;
    step_check("R7");
    chk("R7", "release keeps pull value", in_o, 32'h8888_8888);
  endtask

  task automatic t_float();
    cfg = '0;
    ext_vld = '0;
    ext_lvl = 32'h1234_5678;
    step_check("R6");
    chk("R6", "undriven in follows external level", in_o, 32'h1234_5678);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R1", "short after reset", short_o, '0);
    rst = 1'b0;
    prev_oe = '0;
    prev_lvl = '0;
  endtask

  initial begin
    t_reset();
    t_drive_codes();
    t_pulls();
    t_shorts();
    t_disconnect();
    t_float();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule